// File: doc/BRIEF.md
# Button-Selected Seven-Segment Driver

This block drives a four-digit seven-segment display whose digits share one set of segment lines, so only one digit can glow at any moment. It receives four 4-bit digit values packed into one bus and a 4-bit vector with one bit per push button. When exactly one button is held, the block enables that digit's anode and decodes that digit's value into a segment pattern. The hexadecimal value is shown on the seven segment lines.

The logic is purely combinational and has no clock or reset. Three parts make it up: a check that the button vector is one-hot, a mux that picks the value and an anode mux. A hex decoder sits after the value mux, and its glyphs are package parameters. If no button is held, or if two or more are held, every anode is driven to its off level and the display goes dark.

Top module: `seg_btn_driver`

## Requirements
- R1: Anodes are active low. When exactly one bit k of `btn_sel` is 1, `anode_n[k]` is 0 and every other anode bit is 1. Bit 3 is the leftmost digit A, and bit 0 is the rightmost digit D.
- R2: At no time is more than one bit of `anode_n` at 0.
- R3: When `btn_sel` is 4'b0000, `anode_n` is 4'b1111.
- R4: When two or more bits of `btn_sel` are 1, `anode_n` is 4'b1111.
- R5: Segments are active low and ordered {g,f,e,d,c,b,a} in `seg_n`. The value-to-`seg_n` map is: 0=7'h40, 1=7'h79, 2=7'h24, 3=7'h30, 4=7'h19, 5=7'h12, 6=7'h02, 7=7'h78, 8=7'h00, 9=7'h10, A=7'h08, B=7'h03, C=7'h46, D=7'h21, E=7'h06, F=7'h0E.
- R6: With a valid one-hot select on bit k, `seg_n` shows the R5 pattern of `digits[4k+3:4k]`. Digit A is bits [15:12].
- R7: With an invalid select (none or several bits set), `seg_n` shows the R5 pattern for value 0 (7'h40), whatever the digit inputs are.
- R8: `seg_n` never equals 7'h7F, the all-segments-off code.
- R9: The outputs follow the inputs with no clock, so they settle within the same step as an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits | input | 16 | Four packed digit values; [15:12] is A, [3:0] is D |
| btn_sel | input | 4 | One bit per push button; bit k selects digit lane k |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| anode_n | output | 4 | Active-low digit enables; bit 3 is A |

## Verification
The assertions assume only that the inputs are 2-state values. They check the anodes against the population count of `btn_sel` on every input change. The stimulus covers the empty vector, each single button, pairs of buttons, three buttons and all four buttons. Every hex value is placed in every lane, and distinct values fill the other lanes so that a wrong lane choice shows up.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-low glyphs, bit order {g,f,e,d,c,b,a}
  parameter seg_t GLYPH_0 = 7'h40;
  parameter seg_t GLYPH_1 = 7'h79;
  parameter seg_t GLYPH_2 = 7'h24;
  parameter seg_t GLYPH_3 = 7'h30;
  parameter seg_t GLYPH_4 = 7'h19;
  parameter seg_t GLYPH_5 = 7'h12;
  parameter seg_t GLYPH_6 = 7'h02;
  parameter seg_t GLYPH_7 = 7'h78;
  parameter seg_t GLYPH_8 = 7'h00;
  parameter seg_t GLYPH_9 = 7'h10;
  parameter seg_t GLYPH_A = 7'h08;
  parameter seg_t GLYPH_B = 7'h03;
  parameter seg_t GLYPH_C = 7'h46;
  parameter seg_t GLYPH_D = 7'h21;
  parameter seg_t GLYPH_E = 7'h06;
  parameter seg_t GLYPH_F = 7'h0E;
endpackage

// File: rtl/sel_onehot_check.sv
// Flags a select vector with exactly one bit set.
module sel_onehot_check #(
  parameter int N = 4
) (
  input  logic [N-1:0] sel,
  output logic         valid
);
  logic any_set;
  logic multi_set;

  always_comb begin
    any_set   = 1'b0;
    multi_set = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        multi_set = multi_set | any_set;
        any_set   = 1'b1;
      end
    end
    valid = any_set & ~multi_set;
  end
endmodule

// File: rtl/digit_value_mux.sv
// AND-OR lane select, forced to zero when the select is invalid.
module digit_value_mux #(
  parameter int N = 4,
  parameter int W = 4,
  localparam int BUS_W = N * W
) (
  input  logic [BUS_W-1:0] lanes,
  input  logic [N-1:0]     sel,
  input  logic             valid,
  output logic [W-1:0]     value
);
  logic [N-1:0][W-1:0] masked;

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign masked[k] = lanes[k*W +: W] & {W{sel[k] & valid}};
  end

  always_comb begin
    value = '0;
    for (int k = 0; k < N; k++) value = value | masked[k];
  end
endmodule

// File: rtl/anode_mux.sv
// Active-low enable of the selected digit, or all off.
module anode_mux #(
  parameter int N = 4
) (
  input  logic [N-1:0] sel,
  input  logic         valid,
  output logic [N-1:0] anode_n
);
  always_comb begin
    if (valid) anode_n = ~sel;
    else       anode_n = '1;
  end
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import segdrv_pkg::*;
(
  input  logic [3:0] hex,
  output seg_t       seg_n
);
  always_comb begin
    unique case (hex)
      4'h0: seg_n = GLYPH_0;
      4'h1: seg_n = GLYPH_1;
      4'h2: seg_n = GLYPH_2;
      4'h3: seg_n = GLYPH_3;
      4'h4: seg_n = GLYPH_4;
      4'h5: seg_n = GLYPH_5;
      4'h6: seg_n = GLYPH_6;
      4'h7: seg_n = GLYPH_7;
      4'h8: seg_n = GLYPH_8;
      4'h9: seg_n = GLYPH_9;
      4'hA: seg_n = GLYPH_A;
      4'hB: seg_n = GLYPH_B;
      4'hC: seg_n = GLYPH_C;
      4'hD: seg_n = GLYPH_D;
      4'hE: seg_n = GLYPH_E;
      default: seg_n = GLYPH_F;
    endcase
  end
endmodule

// File: rtl/seg_btn_driver.sv
module seg_btn_driver #(
  parameter int NUM_DIGITS = 4,
  localparam int DIGIT_W = 4,
  localparam int BUS_W = NUM_DIGITS * DIGIT_W
) (
  input  logic [BUS_W-1:0]      digits,
  input  logic [NUM_DIGITS-1:0] btn_sel,
  output logic [6:0]            seg_n,
  output logic [NUM_DIGITS-1:0] anode_n
);
  logic               sel_ok;
  logic [DIGIT_W-1:0] shown_val;

  sel_onehot_check #(.N(NUM_DIGITS)) u_check (
    .sel   (btn_sel),
    .valid (sel_ok)
  );

  digit_value_mux #(.N(NUM_DIGITS), .W(DIGIT_W)) u_vmux (
    .lanes (digits),
    .sel   (btn_sel),
    .valid (sel_ok),
    .value (shown_val)
  );

  anode_mux #(.N(NUM_DIGITS)) u_amux (
    .sel     (btn_sel),
    .valid   (sel_ok),
    .anode_n (anode_n)
  );

  hex_seg_decoder u_dec (
    .hex   (shown_val),
    .seg_n (seg_n)
  );
endmodule

// File: rtl/seg_btn_driver_chk.sv
module seg_btn_driver_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic [NUM_DIGITS-1:0] btn_sel,
  input logic [6:0]            seg_n,
  input logic [NUM_DIGITS-1:0] anode_n
);
  always_comb begin
    a_r2_one_anode_max: assert ($onehot0(~anode_n));
    if ($countones(btn_sel) != 1) begin
      a_r3_r4_blank_on_bad_sel: assert (anode_n == '1);
      a_r7_zero_glyph_on_bad_sel: assert (seg_n == 7'h40);
    end else begin
      a_r1_anode_tracks_button: assert (anode_n == ~btn_sel);
    end
    a_r8_never_all_off: assert (seg_n != 7'h7F);
  end
endmodule

bind seg_btn_driver seg_btn_driver_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .btn_sel (btn_sel),
  .seg_n   (seg_n),
  .anode_n (anode_n)
);

// File: tb/seg_btn_driver_bench.sv
module seg_btn_driver_bench;
  logic        clk;
  logic [15:0] digits;
  logic [3:0]  btn_sel;
  logic [6:0]  seg_n;
  logic [3:0]  anode_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  seg_btn_driver u_seg_btn_driver (
    .digits  (digits),
    .btn_sel (btn_sel),
    .seg_n   (seg_n),
    .anode_n (anode_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [3:0] s);
    @(negedge clk);
    digits  = d;
    btn_sel = s;
    #1;
  endtask

  // R3 startup state: no button held
  task automatic t_idle();
    apply(16'h9ABC, 4'b0000);
    chk("R3", {4'h0, anode_n}, {4'h0, 4'hF});
    chk("R7", {4'h0, seg_n}, {4'h0, 7'h40});
  endtask

  // R1 R6 each button alone, distinct lane values
  task automatic t_single();
    for (int k = 0; k < 4; k++) begin
      apply(16'h5A3C, 4'b1 << k);
      chk("R1", {7'h0, anode_n}, {7'h0, ~(4'b1 << k)});
      chk("R6", {4'h0, seg_n}, {4'h0, glyph(4'(16'h5A3C >> (4*k)))});
    end
  endtask

  // R5 every hex value in every lane; other lanes hold its complement
  task automatic t_all_hex();
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 16; v++) begin
        logic [15:0] d;
        d = {4{~4'(v)}};
        d[4*k +: 4] = 4'(v);
        apply(d, 4'b1 << k);
        chk("R5", {4'h0, seg_n}, {4'h0, glyph(4'(v))});
        chk("R8", {10'h0, seg_n == 7'h7F}, 11'h0);
      end
  endtask

  // R4 R7 R2 several buttons held
  task automatic t_multi();
    logic [3:0] pats [6] = '{4'b0011, 4'b1100, 4'b0101, 4'b1110, 4'b1011, 4'b1111};
    foreach (pats[i]) begin
      apply(16'h8888, pats[i]);
      chk("R4", {7'h0, anode_n}, {7'h0, 4'hF});
      chk("R7", {4'h0, seg_n}, {4'h0, 7'h40});
      chk("R2", {10'h0, $countones(~anode_n) <= 1}, 11'h1);
    end
  endtask

  // R9 output follows a digit change with no clock edge in between
  task automatic t_follow();
    apply(16'h1000, 4'b1000);
    chk("R9", {4'h0, seg_n}, {4'h0, glyph(4'h1)});
    digits = 16'hE000;
    #1;
    chk("R9", {4'h0, seg_n}, {4'h0, glyph(4'hE)});
  endtask

  initial begin
    digits = '0;
    btn_sel = '0;
    t_idle();
    t_single();
    t_all_hex();
    t_multi();
    t_follow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule